// File: doc/BRIEF.md
# Byte-Level I2C Master Controller with Arbitration Handling

This block is a byte-oriented I2C bus master that software drives through three small registers: control, status and data. Setting the master bit puts a START on the bus, and clearing it puts a STOP on the bus. Writing the data register in transmit mode sends one byte. Reading it in receive mode fetches one byte, so the first read only starts a transfer. A repeated START can be requested while the block still owns the bus. SCL and SDA are open-drain: each output pin means "pull the line low", and the input pins carry the wired-AND level of the line.

The bit timing comes from a fixed divider. Each bit takes two halves of `DIV` clock cycles: one half with SCL low, then one half with SCL high. A bus monitor flags the bus as busy on any START or STOP condition, whichever device makes it. The block checks every data bit that it leaves high. If another device pulls SDA low during that bit, the block stops driving SDA, clocks out the rest of the byte, and then releases the bus and drops master mode. A START request made while another device holds the bus is refused.

The control register is at address 0:

| Bit | Function |
|-----|----------|
| 7 | Enable |
| 5 | Master |
| 4 | Transmit |
| 3 | No-ACK |
| 2 | Repeated start (write-only strobe, reads 0) |

The status register is at address 1:

| Bit | Function |
|-----|----------|
| 5 | Busy |
| 4 | Arbitration lost |
| 1 | Transfer flag |
| 0 | Received ACK |

The data register is at address 2. The `irq` output follows the transfer flag.

Top module: `i2cArbMaster`

## Requirements
- R1: After reset the control and status registers read 0x00, both lines are released, and `irq` is low.
- R2: With Enable set and the bus free, a control write that changes Master (bit 5) from 0 to 1 makes SDA fall while SCL is high (a START). A later write that clears Master makes SDA rise while SCL is high (a STOP).
- R3: While the block owns the bus, writing control with bit 2 set produces a new START condition, with no STOP condition before it, and Busy stays set.
- R4: With Transmit (bit 4) set, a data write sends the byte MSB first and then releases SDA for a ninth clock. At the end of that clock the transfer flag (status bit 1) and `irq` are set, and Received ACK (status bit 0) holds the level sampled on the ninth clock.
- R5: With Transmit clear, a data read starts receiving one byte and returns the previously held value, so the first read is a dummy. The next read returns the byte just received. The block drives ACK (SDA low) on the ninth clock.
- R6: With No-ACK (bit 3) set, the ninth clock of a received byte has SDA released (NACK).
- R7: If SDA reads low while SCL is high during a bit the block leaves high, the block releases SDA for the rest of the byte but still makes all nine clocks. It raises the transfer flag only at the end of the ninth clock. It then sets Arbitration lost (status bit 4), clears Master, and releases both lines without a STOP.
- R8: A START request made while Busy is set and SDA or SCL is low is refused. The lines are not driven and no STOP appears. Master reads back 0, and Arbitration lost and the transfer flag are set.
- R9: A START request made while Busy is set but both lines are high proceeds with a START and does not set Arbitration lost.
- R10: A status write clears Arbitration lost and the transfer flag where the written bit is 0. A control write with Enable clear zeroes the control bits and the status flags and releases both lines.
- R11: Busy (status bit 5) is set one cycle after a START condition seen on the inputs, and cleared one cycle after a STOP condition, whichever device made it.
- R12: Data register accesses while the block is not master cause no bus activity and do not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (has side effects on the data register) |
| regAddr | input | 2 | Register address: 0 control, 1 status, 2 data |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from `regAddr` |
| sclIn | input | 1 | Level of the SCL line |
| sdaIn | input | 1 | Level of the SDA line |
| sclOe | output | 1 | Pull SCL low when high |
| sdaOe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Transfer-complete or arbitration interrupt |

## Verification
Busy is due in the second sampling point after a line transition: one register stage holds the previous line level, and a second one holds the flag. The bench model therefore works from line samples taken two of its own sampling points earlier and compares Busy on every clock. Each byte takes 18·DIV cycles, and the transfer flag appears one cycle after the final SCL-high half ends. The bench does not count to that moment. It waits on the flag and then checks how many SCL rising edges its bus monitor saw, which confirms that the flag did not rise early. Register effects of a write are read back from the next cycle on.

// File: rtl/i2cArbPkg.sv
package i2cArbPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BYTE, ST_STOP, ST_RSTART
  } engSt_e;

  typedef struct packed {
    logic       abort;
    logic       start;
    logic       stop;
    logic       restart;
    logic       byteGo;
    logic       isTx;
    logic       nack;
    logic [7:0] txData;
  } engCmd_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/i2cBusEngine.sv
module i2cBusEngine
  import i2cArbPkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  engCmd_t    cmd,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       done,
  output logic       byteLost,
  output logic       lostNow,
  output logic       rxAck,
  output logic [7:0] rxByte,
  output logic       busy
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  engSt_e      st;
  logic [1:0]  ph;
  logic [CW-1:0] cnt;
  logic [3:0]  bitIdx;
  logic [7:0]  shReg;
  logic        txMode, nackQ, lostQ;
  logic        pendByte, pendTx, pendNack, pendStop, pendRs;
  logic [7:0]  pendData;
  logic        sclQ, sdaQ;

  wire tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE; ph <= '0; cnt <= '0; bitIdx <= '0; shReg <= '0;
      txMode <= 1'b0; nackQ <= 1'b0; lostQ <= 1'b0;
      pendByte <= 1'b0; pendTx <= 1'b0; pendNack <= 1'b0; pendData <= '0;
      pendStop <= 1'b0; pendRs <= 1'b0;
      done <= 1'b0; byteLost <= 1'b0; rxAck <= 1'b0;
    end else if (cmd.abort) begin
      st <= ST_IDLE; ph <= '0; cnt <= '0; lostQ <= 1'b0;
      pendByte <= 1'b0; pendStop <= 1'b0; pendRs <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd.byteGo) begin
        pendByte <= 1'b1; pendTx <= cmd.isTx; pendNack <= cmd.nack; pendData <= cmd.txData;
      end
      if (cmd.stop)    pendStop <= 1'b1;
      if (cmd.restart) pendRs   <= 1'b1;
      cnt <= (st == ST_IDLE || st == ST_HOLD || tick) ? '0 : cnt + 1'b1;
      case (st)
        ST_IDLE: if (cmd.start) begin st <= ST_START; ph <= '0; lostQ <= 1'b0; end
        ST_START: if (tick) begin
          if (ph == 2'd1) begin st <= ST_HOLD; ph <= '0; end else ph <= ph + 1'b1;
        end
        ST_HOLD: begin
          if (pendRs) begin
            pendRs <= 1'b0; st <= ST_RSTART; ph <= '0;
          end else if (pendByte) begin
            pendByte <= 1'b0; st <= ST_BYTE; ph <= '0; bitIdx <= '0; lostQ <= 1'b0;
            shReg <= pendData; txMode <= pendTx; nackQ <= pendNack;
          end else if (pendStop) begin
            pendStop <= 1'b0; st <= ST_STOP; ph <= '0;
          end
        end
        ST_BYTE: if (tick) begin
          if (ph == 2'd0) ph <= 2'd1;
          else begin
            ph <= '0;
            if (bitIdx == 4'd8) begin
              rxAck <= sdaIn; done <= 1'b1; byteLost <= lostQ;
              st <= lostQ ? ST_IDLE : ST_HOLD;
            end else begin
              if (txMode && shReg[7] && !sdaIn) lostQ <= 1'b1;
              shReg  <= {shReg[6:0], sdaIn};
              bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        ST_STOP: if (tick) begin
          if (ph == 2'd2) begin st <= ST_IDLE; ph <= '0; end else ph <= ph + 1'b1;
        end
        ST_RSTART: if (tick) begin
          if (ph == 2'd3) begin st <= ST_HOLD; ph <= '0; end else ph <= ph + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sclOe = 1'b0;
    sdaOe = 1'b0;
    case (st)
      ST_START:  begin sdaOe = 1'b1; sclOe = (ph == 2'd1); end
      ST_HOLD:   sclOe = 1'b1;
      ST_BYTE: begin
        sclOe = (ph == 2'd0);
        if (bitIdx == 4'd8) sdaOe = !txMode && !nackQ;
        else                sdaOe = txMode && !shReg[7] && !lostQ;
      end
      ST_STOP:   begin sclOe = (ph != 2'd1 && ph != 2'd2) ? 1'b1 : (ph == 2'd1 ? 1'b0 : 1'b0);
                       sclOe = (ph == 2'd0); sdaOe = (ph != 2'd2); end
      ST_RSTART: begin sclOe = (ph == 2'd0 || ph == 2'd3); sdaOe = (ph >= 2'd2); end
      default: ;
    endcase
  end

  assign rxByte  = shReg;
  assign lostNow = lostQ;

  // bus condition monitor, independent of who drives the lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1; sdaQ <= 1'b1; busy <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (sclIn && sclQ && sdaQ && !sdaIn)      busy <= 1'b1;
      else if (sclIn && sclQ && !sdaQ && sdaIn) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       engDone,
  input  logic       engByteLost,
  input  logic       engRxAck,
  input  logic [7:0] engRxByte,
  input  logic       busBusy,
  output engCmd_t    cmd,
  output logic       ctrlEn,
  output logic       ctrlMsta,
  output logic       statAl,
  output logic       irq
);
  logic mtx, txak, iif, rxak, master, rxPend;
  logic [7:0] dataReg;

  wire wrCtrl = regWe && regAddr == ADDR_CTRL;
  wire wrStat = regWe && regAddr == ADDR_STAT;
  wire wrData = regWe && regAddr == ADDR_DATA;
  wire rdData = regRe && regAddr == ADDR_DATA;

  wire wantStart    = wrCtrl && regWdata[7] && regWdata[5] && !ctrlMsta && !master;
  wire startBlocked = wantStart && busBusy && !(sclIn && sdaIn);

  always_comb begin
    cmd         = '0;
    cmd.abort   = wrCtrl && !regWdata[7];
    cmd.start   = wantStart && !startBlocked;
    cmd.stop    = wrCtrl && regWdata[7] && !regWdata[5] && master;
    cmd.restart = wrCtrl && regWdata[7] && regWdata[5] && regWdata[2] && master;
    cmd.byteGo  = master && ((wrData && mtx) || (rdData && !mtx));
    cmd.isTx    = mtx;
    cmd.nack    = txak;
    cmd.txData  = regWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn <= 1'b0; ctrlMsta <= 1'b0; mtx <= 1'b0; txak <= 1'b0;
      statAl <= 1'b0; iif <= 1'b0; rxak <= 1'b0; master <= 1'b0;
      rxPend <= 1'b0; dataReg <= '0;
    end else begin
      if (wrCtrl) begin
        if (!regWdata[7]) begin
          ctrlEn <= 1'b0; ctrlMsta <= 1'b0; mtx <= 1'b0; txak <= 1'b0;
          statAl <= 1'b0; iif <= 1'b0; rxak <= 1'b0; master <= 1'b0; rxPend <= 1'b0;
        end else begin
          ctrlEn <= 1'b1; mtx <= regWdata[4]; txak <= regWdata[3];
          if (startBlocked) begin
            ctrlMsta <= 1'b0; statAl <= 1'b1; iif <= 1'b1;
          end else ctrlMsta <= regWdata[5];
          if (cmd.start) master <= 1'b1;
          if (cmd.stop)  master <= 1'b0;
        end
      end
      if (wrStat) begin
        statAl <= statAl & regWdata[4];
        iif    <= iif & regWdata[1];
      end
      if (wrData)     dataReg <= regWdata;
      if (cmd.byteGo) rxPend  <= !cmd.isTx;
      if (engDone && ctrlEn) begin
        iif  <= 1'b1;
        rxak <= engRxAck;
        if (rxPend) dataReg <= engRxByte;
        if (engByteLost) begin
          statAl <= 1'b1; ctrlMsta <= 1'b0; master <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = {ctrlEn, 1'b0, ctrlMsta, mtx, txak, 3'b000};
      ADDR_STAT: regRdata = {2'b00, busBusy, statAl, 2'b00, iif, rxak};
      ADDR_DATA: regRdata = dataReg;
      default:   regRdata = '0;
    endcase
  end

  assign irq = iif;
endmodule

// File: rtl/i2cArbMaster.sv
module i2cArbMaster
  import i2cArbPkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       irq
);
  engCmd_t    cmd;
  logic       engDone, engByteLost, engLost, engRxAck, statBusy;
  logic       ctrlEn, ctrlMsta, statAl;
  logic [7:0] engRxByte;

  i2cRegCtrl uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclIn(sclIn), .sdaIn(sdaIn),
    .engDone(engDone), .engByteLost(engByteLost), .engRxAck(engRxAck),
    .engRxByte(engRxByte), .busBusy(statBusy), .cmd(cmd), .ctrlEn(ctrlEn),
    .ctrlMsta(ctrlMsta), .statAl(statAl), .irq(irq)
  );

  i2cBusEngine #(.DIV(DIV)) uEng (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .done(engDone), .byteLost(engByteLost),
    .lostNow(engLost), .rxAck(engRxAck), .rxByte(engRxByte), .busy(statBusy)
  );
endmodule

// File: rtl/i2cArbMasterChk.sv
module i2cArbMasterChk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic sclOe,
  input logic sdaOe,
  input logic ctrlEn,
  input logic ctrlMsta,
  input logic statAl,
  input logic statBusy,
  input logic engLost
);
  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> (!sclOe && !sdaOe)); // R10
  AST_LOST_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statAl) |-> !ctrlMsta); // R7
  AST_LOST_NO_SDA: assert property (@(posedge clk) disable iff (!rstN)
    engLost |-> !sdaOe); // R7
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && $past(sdaIn) && !sdaIn) |=> statBusy); // R11
  AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && !$past(sdaIn) && sdaIn) |=> !statBusy); // R11
endmodule

bind i2cArbMaster i2cArbMasterChk uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sclOe(sclOe),
  .sdaOe(sdaOe), .ctrlEn(ctrlEn), .ctrlMsta(ctrlMsta), .statAl(statAl),
  .statBusy(statBusy), .engLost(engLost)
);

// File: tb/tb_i2cArbMaster.sv
`timescale 1ns/1ps
module tb_i2cArbMaster;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [1:0] regAddr = 2'd1;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic sclOe, sdaOe, irq;
  logic tbSclLow = 1'b0, tbSdaLow = 1'b0;
  wire sclLine = !sclOe && !tbSclLow;
  wire sdaLine = !sdaOe && !tbSdaLow;

  int cmpCnt = 0, errCnt = 0;
  int startCnt = 0, stopCnt = 0;
  logic bitsQ[$];

  always #2.5 clk = ~clk;

  i2cArbMaster #(.DIV(4)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    cmpCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
  endtask

  // bus observer
  initial forever begin @(posedge sclLine); bitsQ.push_back(sdaLine); end
  initial forever begin @(negedge sdaLine); if (sclLine) startCnt++; end
  initial forever begin @(posedge sdaLine); if (sclLine) stopCnt++; end

  // behavioural busy model, compared on every clock while status is selected (R11)
  initial begin
    logic [1:0] h1, h2, cur;
    logic expBusy;
    h1 = 2'b11; h2 = 2'b11; expBusy = 1'b0;
    forever begin
      @(negedge clk); #1;
      cur = {sclLine, sdaLine};
      if (!rstN) begin
        expBusy = 1'b0; h1 = cur; h2 = cur;
      end else begin
        if (h2[1] && h1[1] && h2[0] && !h1[0]) expBusy = 1'b1;
        else if (h2[1] && h1[1] && !h2[0] && h1[0]) expBusy = 1'b0;
        if (regAddr == 2'd1) check("R11 busy model", int'(regRdata[5]), int'(expBusy));
        h2 = h1; h1 = cur;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0; regAddr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; regRe = 1'b1; #1 v = regRdata;
    @(negedge clk); regRe = 1'b0; regAddr = 2'd1;
  endtask

  task automatic waitBusy(input logic val);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1; if (regRdata[5] == val) break;
    end
  endtask

  task automatic waitIrq();
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (irq) break; end
  endtask

  task automatic waitBits(input int n);
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (bitsQ.size() >= n) break; end
  endtask

  // slave-side pulls, pull[8] for the first bit, pull[0] for the ninth
  task automatic serve(input logic [8:0] pull);
    tbSdaLow = pull[8];
    for (int i = 7; i >= 0; i--) begin @(negedge sclLine); #1; tbSdaLow = pull[i]; end
    @(negedge sclLine); #1; tbSdaLow = 1'b0;
  endtask

  function automatic logic [7:0] qByte();
    logic [7:0] b = '0;
    for (int i = 0; i < 8; i++) b = {b[6:0], bitsQ[i]};
    return b;
  endfunction

  initial begin
    logic [7:0] v;
    int s0, p0;
    logic drove;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    rd(2'd0, v); check("R1 ctrl after reset", v, 8'h00);
    rd(2'd1, v); check("R1 status after reset", v, 8'h00);
    check("R1 lines released", {sclLine, sdaLine, irq}, 3'b110);

    // R2 start, R4 transmit with ACK
    wr(2'd0, 8'h80); wr(2'd1, 8'h00); wr(2'd0, 8'hB0);
    waitBusy(1'b1);
    check("R2 start seen", startCnt, 1);
    repeat (20) @(negedge clk);
    bitsQ.delete();
    fork serve(9'b0_0000_0001); wr(2'd2, 8'hA6); join
    waitIrq(); @(negedge clk);
    check("R4 bits sent", int'(qByte()), 8'hA6);
    check("R4 ninth clock count", bitsQ.size(), 9);
    rd(2'd1, v); check("R4 status after acked byte", v, 8'h22);
    check("R4 irq", irq, 1);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R10 flags cleared by status write", v, 8'h20);

    // R4 NACKed byte
    fork serve(9'b0); wr(2'd2, 8'h3C); join
    waitIrq(); @(negedge clk);
    rd(2'd1, v); check("R4 rxak on nack", v, 8'h23);
    wr(2'd1, 8'h00);

    // R3 repeated start
    p0 = stopCnt;
    wr(2'd0, 8'hB4);
    for (int i = 0; i < 200 && startCnt < 2; i++) @(negedge clk);
    check("R3 repeated start", startCnt, 2);
    check("R3 no stop between", stopCnt, p0);
    rd(2'd1, v); check("R3 busy kept", int'(v[5]), 1);
    repeat (10) @(negedge clk);
    fork serve(9'b0_0000_0001); wr(2'd2, 8'h91); join
    waitIrq(); wr(2'd1, 8'h00);

    // R5 receive with ACK, dummy read
    wr(2'd0, 8'hA0);
    bitsQ.delete();
    fork serve({~8'hC3, 1'b0}); rd(2'd2, v); join
    waitIrq(); @(negedge clk);
    check("R5 master ack on ninth", int'(bitsQ[8]), 0);
    check("R5 line byte", int'(qByte()), 8'hC3);
    wr(2'd1, 8'h00);
    // R6 no-ACK on the next byte; this read returns the first byte
    wr(2'd0, 8'hA8);
    bitsQ.delete();
    fork serve({~8'h5E, 1'b0}); rd(2'd2, v); join
    check("R5 first received byte", v, 8'hC3);
    waitIrq(); @(negedge clk);
    check("R6 nack on ninth", int'(bitsQ[8]), 1);
    wr(2'd1, 8'h00);
    p0 = stopCnt;
    wr(2'd0, 8'h80);
    waitBusy(1'b0);
    check("R2 stop seen", stopCnt, p0 + 1);
    // R12 data read when not master
    bitsQ.delete();
    rd(2'd2, v); check("R5 last received byte", v, 8'h5E);
    repeat (100) @(negedge clk);
    check("R12 no clocks when not master", bitsQ.size(), 0);
    check("R12 no irq when not master", irq, 0);

    // R7 arbitration loss
    wr(2'd0, 8'hB0);
    waitBusy(1'b1);
    repeat (10) @(negedge clk);
    bitsQ.delete();
    fork
      begin tbSdaLow = 1'b0; repeat (2) begin @(negedge sclLine); #1; end tbSdaLow = 1'b1; end
      wr(2'd2, 8'hFF);
    join
    waitBits(8);
    check("R7 no irq before ninth clock", irq, 0);
    check("R7 sda released after loss", sdaOe, 0);
    waitIrq(); @(negedge clk);
    check("R7 all nine clocks", bitsQ.size(), 9);
    rd(2'd1, v); check("R7 status after loss", v, 8'h32);
    rd(2'd0, v); check("R7 master cleared", v, 8'h90);
    check("R7 lines released", {sclOe, sdaOe}, 2'b00);
    @(negedge clk); tbSdaLow = 1'b0;
    waitBusy(1'b0);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R10 al cleared", v, 8'h00);

    // R8 start refused while another device holds SDA low
    @(negedge clk); tbSdaLow = 1'b1;
    waitBusy(1'b1);
    s0 = startCnt; p0 = stopCnt;
    wr(2'd0, 8'hB0);
    drove = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sclOe || sdaOe) drove = 1'b1; end
    check("R8 no drive", drove, 0);
    rd(2'd1, v); check("R8 status refused start", v, 8'h32);
    rd(2'd0, v); check("R8 master reads 0", v, 8'h90);
    check("R8 no stop made", stopCnt, p0);
    check("R8 no start made", startCnt, s0);
    @(negedge clk); tbSdaLow = 1'b0;
    waitBusy(1'b0);
    // R10 disable clears
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R10 ctrl after disable", v, 8'h00);
    rd(2'd1, v); check("R10 status after disable", v, 8'h00);
    check("R10 irq after disable", irq, 0);

    // R9 busy bus but both lines high
    wr(2'd0, 8'h80);
    @(negedge clk); tbSdaLow = 1'b1;
    repeat (4) @(negedge clk); tbSclLow = 1'b1;
    repeat (4) @(negedge clk); tbSdaLow = 1'b0;
    repeat (4) @(negedge clk); tbSclLow = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd1, v); check("R9 bus busy with lines high", int'(v[5]), 1);
    s0 = startCnt;
    wr(2'd0, 8'hB0);
    for (int i = 0; i < 200 && startCnt == s0; i++) @(negedge clk);
    check("R9 start proceeds", startCnt, s0 + 1);
    rd(2'd1, v); check("R9 no arbitration flag", int'(v[4]), 0);
    repeat (20) @(negedge clk);
    wr(2'd0, 8'h90);
    waitBusy(1'b0);
    rd(2'd1, v); check("R2 busy cleared after stop", v, 8'h00);

    repeat (10) @(negedge clk);
    summary();
    $finish;
  end
endmodule